// File: doc/BRIEF.md
# Quadrature Oscillator Mixer with CIC Decimator

This block is the front end of a wideband digital down converter. It accepts one real, signed ADC sample per clock. It mixes that sample with a numerically controlled sine/cosine pair to produce in-phase and quadrature products. Both products are then decimated by a cascaded integrator-comb filter, and the result is complex samples at one sixteenth of the input rate. A single write port loads the frequency tuning word.

The oscillator is a 48-bit phase accumulator, so the frequency step is the clock rate divided by 2^48. The top 10 accumulator bits address a 1024-entry sine table. Cosine comes from the same table, shifted by a quarter cycle. Products are rounded to 18 bits. Each branch then runs through five integrators, a divide-by-16 rate divider and five single-delay combs. Registers are 38 bits wide, which is 18 bits plus five stages times log2(16). Sharper channel filtering and droop correction belong to the stage that follows this block.

Top module: `ddc_front`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, integrators, combs and rate divider are cleared, and in the following cycle `out_valid`, `out_i` and `out_q` are all zero.
- R2: Each clock, the phase register advances by the tuning word, modulo 2^48. Table address a is phase bits [47:38]. Sine is entry a, and cosine is entry (a+256) mod 1024. Entry k equals round(32767·sin(2πk/1024)), with ties rounded away from zero. A word of 2^46 gives a quarter-rate tone, and the decimated I and Q outputs are then exactly zero.
- R3: A word written with `tune_we` at one edge is first added at the next edge. Writing never resets the phase, so the phase reached under the old word is kept.
- R4: The in-phase product is x·cos and the quadrature product is x·sin. Each 30-bit product p is reduced to floor((p+2048)/4096), which is 18 bits signed.
- R5: Each branch is a 5-stage CIC with rate 16 and differential delay 1 in 38-bit registers. For a constant product m, the settled output is m·2^20.
- R6: The integrators wrap in two's complement without saturating. A full-scale negative input held for hundreds of cycles still yields the exact settled output.
- R7: `out_valid` is a single-cycle pulse, and consecutive pulses are exactly 16 clocks apart.
- R8: The first five decimated results after reset are suppressed. The first `out_valid` appears in the cycle after the 96th clock edge following reset release.
- R9: `out_i` and `out_q` change only in cycles where `out_valid` is high, and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one ADC sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| tune_we | input | 1 | Load strobe for the tuning word |
| tune_word | input | 48 | Phase increment per clock |
| adc_in | input | 14 | Signed real input sample |
| out_valid | output | 1 | One-cycle pulse marking a new decimated sample |
| out_i | output | 38 | Signed in-phase decimated output |
| out_q | output | 38 | Signed quadrature decimated output |

## Verification
The assertions assume that reset is held high for at least two clocks at start-up, so the hold check starts from registers that have already been cleared. They also assume that reset, once released, stays low, so the rate divider runs without interruption. The stimulus holds reset for four cycles at the start of every scenario and never pulses it while data is flowing. Input samples and tuning words change only at falling edges. The bench checks settled values only after twenty decimated outputs, so the wrap-around and mixing transients have left the comb window before any comparison.

// File: rtl/ddc_front.sv
module ddc_front #(
  parameter int PW = 48,
  parameter int AW = 10,
  parameter int SW = 16,
  parameter int XW = 14,
  parameter int MW = 18,
  parameter int N  = 5,
  parameter int RL = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tune_we,
  input  logic [PW-1:0]                 tune_word,
  input  logic signed [XW-1:0]          adc_in,
  output logic                          out_valid,
  output logic signed [MW+N*RL-1:0]     out_i,
  output logic signed [MW+N*RL-1:0]     out_q
);
  localparam int CW = MW + N * RL;
  localparam int PX = XW + SW;
  localparam int SH = PX - MW;
  localparam int TD = 1 << AW;
  localparam int FW = $clog2(N + 1);
  localparam logic [FW-1:0] FULL = FW'(N);
  localparam logic [AW-1:0] QTR = AW'(TD / 4);
  localparam logic signed [PX-1:0] HALF = PX'(1) <<< (SH - 1);

  logic [PW-1:0] tw, ph;
  logic signed [SW-1:0] lut [TD];
  logic signed [SW-1:0] s_r, c_r;
  logic signed [XW-1:0] x_r;
  logic signed [MW-1:0] mi, mq;
  logic signed [CW-1:0] ai [N], aq [N];
  logic signed [CW-1:0] di [N], dq [N];
  logic signed [CW-1:0] ci [N+1], cq [N+1];
  logic [RL-1:0] dcnt;
  logic [FW-1:0] fill;
  logic strobe, emit;

  initial begin
    real v;
    for (int k = 0; k < TD; k++) begin
      v = real'((1 << (SW - 1)) - 1) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(TD));
      lut[k] = SW'($rtoi(v < 0.0 ? v - 0.5 : v + 0.5));
    end
  end

  wire [AW-1:0] addr = ph[PW-1 -: AW];
  assign strobe = &dcnt;
  assign emit   = strobe && (fill == FULL);

  always_ff @(posedge clk)
    if (tune_we) tw <= tune_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      s_r <= '0;
      c_r <= '0;
      x_r <= '0;
      mi  <= '0;
      mq  <= '0;
    end else begin
      ph  <= ph + tw;
      s_r <= lut[addr];
      c_r <= lut[addr + QTR];
      x_r <= adc_in;
      mi  <= MW'((PX'(x_r) * PX'(c_r) + HALF) >>> SH);
      mq  <= MW'((PX'(x_r) * PX'(s_r) + HALF) >>> SH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        ai[k] <= '0;
        aq[k] <= '0;
      end
    end else begin
      ai[0] <= ai[0] + CW'(mi);
      aq[0] <= aq[0] + CW'(mq);
      for (int k = 1; k < N; k++) begin
        ai[k] <= ai[k] + ai[k-1];
        aq[k] <= aq[k] + aq[k-1];
      end
    end
  end

  always_comb begin
    ci[0] = ai[N-1];
    cq[0] = aq[N-1];
    for (int k = 0; k < N; k++) begin
      ci[k+1] = ci[k] - di[k];
      cq[k+1] = cq[k] - dq[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt      <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      for (int k = 0; k < N; k++) begin
        di[k] <= '0;
        dq[k] <= '0;
      end
    end else begin
      dcnt      <= dcnt + 1'b1;
      out_valid <= emit;
      if (strobe) begin
        if (fill != FULL) fill <= fill + 1'b1;
        for (int k = 0; k < N; k++) begin
          di[k] <= ci[k];
          dq[k] <= cq[k];
        end
      end
      if (emit) begin
        out_i <= ci[N];
        out_q <= cq[N];
      end
    end
  end
endmodule

// File: rtl/ddc_front_chk.sv
module ddc_front_chk #(
  parameter int RL = 4,
  parameter int N  = 5,
  parameter int CW = 38
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic signed [CW-1:0] out_i,
  input logic signed [CW-1:0] out_q
);
  localparam int RATE  = 1 << RL;
  localparam int FIRST = RATE * (N + 1);

  logic [15:0] cyc, gap;
  logic seen, rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      cyc  <= '0;
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (cyc != 16'hFFFF) cyc <= cyc + 1'b1;
      if (out_valid) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_q)
      AST_RESET_CLEAR: assert (!out_valid && out_i == '0 && out_q == '0); // R1

  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (rst) out_valid |-> cyc >= 16'(FIRST)); // R8
  AST_VALID_GAP: assert property (@(posedge clk) disable iff (rst) (out_valid && seen) |-> gap == 16'(RATE - 1)); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R7
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst) !out_valid |-> ($stable(out_i) && $stable(out_q))); // R9
endmodule

bind ddc_front ddc_front_chk #(.RL(RL), .N(N), .CW(MW + N * RL)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/ddc_front_tb.sv
module ddc_front_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tune_we = 1'b0;
  logic [47:0] tune_word = '0;
  logic signed [13:0] adc_in = '0;
  logic out_valid;
  logic signed [37:0] out_i, out_q;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ddc_front u_dut (
    .clk(clk), .rst(rst), .tune_we(tune_we), .tune_word(tune_word),
    .adc_in(adc_in), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  function automatic longint lutv(int k);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(k % 1024) / 1024.0);
    return longint'($rtoi(v < 0.0 ? v - 0.5 : v + 0.5));
  endfunction

  function automatic longint settled(longint x, longint c);
    longint m;
    m = (x * c + 2048) >>> 12;
    return m * (longint'(1) <<< 20);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic signed [13:0] x, logic [47:0] w);
    @(negedge clk);
    rst = 1'b1;
    adc_in = x;
    tune_we = 1'b1;
    tune_word = w;
    repeat (4) @(negedge clk);
    tune_we = 1'b0;
    rst = 1'b0;
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!out_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(14'sd1000, '0);
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(out_i == '0, "R1 out_i", longint'(out_i), 0);
    check(out_q == '0, "R1 out_q", longint'(out_q), 0);
  endtask

  task automatic t_timing();
    int n;
    longint v;
    do_reset(14'sd1000, '0);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!out_valid && n < 1000);
    check(n == 96, "R8 first valid edge", n, 96);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!out_valid && n < 1000);
    check(n == 16, "R7 valid spacing", n, 16);
    v = longint'(out_i);
    @(negedge clk);
    check(!out_valid && longint'(out_i) == v, "R9 hold between pulses", longint'(out_i), v);
  endtask

  task automatic t_dc(logic signed [13:0] x, string tag);
    longint ei, eq;
    do_reset(x, '0);
    repeat (20) wait_valid();
    ei = settled(longint'(x), lutv(256));
    eq = settled(longint'(x), lutv(0));
    check(longint'(out_i) == ei, {tag, " dc in-phase"}, longint'(out_i), ei);
    check(longint'(out_q) == eq, {tag, " dc quadrature"}, longint'(out_q), eq);
  endtask

  task automatic t_quarter_rate();
    do_reset(14'sd1000, 48'h4000_0000_0000);
    repeat (20) wait_valid();
    check(out_i == '0, "R2 quarter-rate I", longint'(out_i), 0);
    check(out_q == '0, "R2 quarter-rate Q", longint'(out_q), 0);
  endtask

  task automatic t_phase(int steps);
    int a;
    longint ei, eq;
    do_reset(14'sd1000, '0);
    repeat (3) @(negedge clk);
    tune_we = 1'b1;
    tune_word = 48'h4000_0000_0000;
    repeat (steps) @(negedge clk);
    tune_word = '0;
    @(negedge clk);
    tune_we = 1'b0;
    repeat (20) wait_valid();
    a = (steps * 256) % 1024;
    ei = settled(1000, lutv(a + 256));
    eq = settled(1000, lutv(a));
    check(longint'(out_i) == ei, "R3 held phase I", longint'(out_i), ei);
    check(longint'(out_q) == eq, "R3 held phase Q", longint'(out_q), eq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_dc(14'sd1000, "R4 R5");
    t_dc(-14'sd8192, "R6 wrap");
    t_quarter_rate();
    t_phase(1);
    t_phase(2);
    t_phase(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule